// File: doc/BRIEF.md
# Procedure Frame Marker Controller

This block keeps the linkage between nested procedure frames on a stack that lives in ordinary memory and grows toward higher addresses. It holds three address registers: the fixed base of the stack, the current top of stack (`sp`) and a frame link register (`q`). On a call request it appends a four-word marker above the current top of stack. After the call, `q` points at the last word of that marker. On a return request it reads the marker back, hands the saved program counter and status to the caller, and unwinds `q` and `sp` to the frame below.

Frames are chained by a relative distance. The last word of each marker holds how far its own address lies above the previous marker's last word. A return therefore needs only one subtraction to find the previous frame. Marker words move one per memory transaction over a single-port request/ready interface. The block reports busy while a sequence runs. It refuses a call that would cross the stack limit and a return when no frame is active.

Top module: `proc_marker_ctl`

## Requirements
- R1: After reset `sp` and `q` both equal BASE-1, which is the empty stack. `busy`, `mem_req`, `ret_valid`, `ovf_flag` and `udf_flag` are all 0.
- R2: An accepted call writes four words to addresses sp+1, sp+2, sp+3 and sp+4, in that order. Their contents are the call program counter (offset 0), the call status (offset 1), zero (offset 2) and the link distance (offset 3). The program counter and status are those sampled in the accepting cycle.
- R3: When an accepted call completes, `sp` and `q` both equal the old `sp` plus 4.
- R4: The link word written at offset 3 equals the new `q` minus the old `q`.
- R5: An accepted return reads offsets 0, 1 and 3 of the marker at q-3..q and never offset 2. At completion `q` becomes old `q` minus the stored link and `sp` becomes old `q` minus 4.
- R6: When a return completes, `ret_valid` pulses high for one cycle. In that same cycle `ret_pc` and `ret_status` hold offsets 0 and 1 of the removed marker, `busy` is low and `sp`/`q` already hold their new values.
- R7: A call is refused when sp+4 exceeds `stack_limit`; a call with sp+4 equal to the limit is accepted. A refused call raises `ovf_flag` for one cycle in the cycle after the request. It issues no memory request and leaves `sp` and `q` unchanged.
- R8: A return requested while `q` equals BASE-1 raises `udf_flag` for one cycle in the cycle after the request. It issues no memory request and leaves `sp` and `q` unchanged.
- R9: `busy` is high from the cycle after acceptance until the sequence completes. Call or return requests made while `busy` is high are ignored.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady. A word is transferred on each clock edge where both are high.
- R11: If a call and a return are both requested in the same idle cycle, the call is served and the return is dropped.
- R12: Calls nest to any depth within the limit. Returns unwind them in reverse order and restore each earlier `sp`/`q` pair exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Request a procedure call (sampled while idle) |
| call_pc | input | DW | Return program counter to save |
| call_status | input | DW | Status word to save |
| ret_req | input | 1 | Request a procedure return (sampled while idle) |
| stack_limit | input | AW | Highest address the stack may use |
| busy | output | 1 | Marker sequence in progress |
| sp | output | AW | Current top-of-stack address |
| q | output | AW | Address of last word of the current marker |
| ret_pc | output | DW | Program counter read back on return |
| ret_status | output | DW | Status word read back on return |
| ret_valid | output | 1 | One-cycle pulse when a return completes |
| ovf_flag | output | 1 | One-cycle pulse: call refused at the limit |
| udf_flag | output | 1 | One-cycle pulse: return with no active frame |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Transaction accepted this cycle |

## Verification
The bench fills the stack to exactly the limit and then asks for one more frame. An off-by-one in the room test would either refuse the last legal frame or write a marker past the limit. It unwinds every frame and then returns once more on the empty stack. A design with a broken emptiness test would read below the base and corrupt `q`. It also rewrites a stored link to a distance other than four, so a design that unwinds by a fixed frame size instead of the stored distance lands `q` at the wrong address. Simultaneous call/return requests, requests raised while busy, and memory wait states from zero to two cycles per word catch a design that favours the wrong request, restarts mid-sequence, or moves its address before the transfer is accepted.

// File: rtl/psm_pkg.sv
package psm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CALL = 2'd1,
        PH_RET  = 2'd2
    } phase_t;

    localparam int MARK_WORDS = 4;

    localparam logic [1:0] W_PC   = 2'd0;
    localparam logic [1:0] W_STAT = 2'd1;
    localparam logic [1:0] W_RSV  = 2'd2;
    localparam logic [1:0] W_LINK = 2'd3;
endpackage

// File: rtl/psm_seq.sv
module psm_seq
    import psm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       call_req,
    input  logic       ret_req,
    input  logic       room_ok,
    input  logic       frame_live,
    input  logic       mem_ready,
    output phase_t     phase,
    output logic [1:0] widx,
    output logic       mem_req,
    output logic       mem_we,
    output logic       call_accept,
    output logic       call_done,
    output logic       ret_done,
    output logic       ovf_p,
    output logic       udf_p,
    output logic       busy
);
    typedef struct packed {
        phase_t     phase;
        logic [1:0] widx;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d         = s_q;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        call_accept = 1'b0;
        call_done   = 1'b0;
        ret_done    = 1'b0;
        ovf_p       = 1'b0;
        udf_p       = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (call_req) begin
                    if (room_ok) begin
                        call_accept = 1'b1;
                        s_d.phase   = PH_CALL;
                        s_d.widx    = W_PC;
                    end else begin
                        ovf_p = 1'b1;
                    end
                end else if (ret_req) begin
                    if (frame_live) begin
                        s_d.phase = PH_RET;
                        s_d.widx  = W_PC;
                    end else begin
                        udf_p = 1'b1;
                    end
                end
            end
            PH_CALL: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    if (s_q.widx == W_LINK) begin
                        call_done = 1'b1;
                        s_d.phase = PH_IDLE;
                        s_d.widx  = W_PC;
                    end else begin
                        s_d.widx = s_q.widx + 2'd1;
                    end
                end
            end
            PH_RET: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    if (s_q.widx == W_LINK) begin
                        ret_done  = 1'b1;
                        s_d.phase = PH_IDLE;
                        s_d.widx  = W_PC;
                    end else if (s_q.widx == W_STAT) begin
                        s_d.widx = W_LINK;
                    end else begin
                        s_d.widx = s_q.widx + 2'd1;
                    end
                end
            end
            default: s_d = '{phase: PH_IDLE, widx: W_PC};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, widx: W_PC};
        else        s_q <= s_d;
    end

    assign phase = s_q.phase;
    assign widx  = s_q.widx;
    assign busy  = (s_q.phase != PH_IDLE);

    // R9: a sequence does not end while a transfer is still outstanding
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> busy);

    // R5: the reserved marker word is never fetched on return
    p_ret_skip_rsv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RET) |-> (widx != W_RSV));

    // R2: call words advance strictly in address order
    p_call_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CALL && mem_ready && widx != W_LINK) |=> (widx == $past(widx) + 2'd1));
endmodule

// File: rtl/psm_frame.sv
module psm_frame
    import psm_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int BASE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic [1:0]    widx,
    input  logic          call_accept,
    input  logic          call_done,
    input  logic          ret_done,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] call_pc,
    input  logic [DW-1:0] call_status,
    input  logic [AW-1:0] stack_limit,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] q,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] ret_pc,
    output logic [DW-1:0] ret_status,
    output logic          ret_valid,
    output logic          room_ok,
    output logic          frame_live
);
    localparam logic [AW-1:0] EMPTY = AW'(BASE - 1);
    localparam logic [AW-1:0] MW    = AW'(MARK_WORDS);
    localparam logic [AW:0]   MWX   = (AW+1)'(MARK_WORDS);

    typedef struct packed {
        logic [AW-1:0] sp;
        logic [AW-1:0] q;
        logic [DW-1:0] pc_l;
        logic [DW-1:0] st_l;
        logic [DW-1:0] rpc;
        logic [DW-1:0] rst;
        logic          rvalid;
    } frm_t;

    frm_t f_q, f_d;
    logic [AW-1:0] link_now;

    always_comb begin
        link_now = f_q.sp + MW - f_q.q;
        room_ok  = ({1'b0, f_q.sp} + MWX) <= {1'b0, stack_limit};
        frame_live = (f_q.q != EMPTY);

        mem_addr  = '0;
        mem_wdata = '0;
        if (phase == PH_CALL) begin
            mem_addr = f_q.sp + AW'(1) + AW'(widx);
            case (widx)
                W_PC:    mem_wdata = f_q.pc_l;
                W_STAT:  mem_wdata = f_q.st_l;
                W_RSV:   mem_wdata = '0;
                default: mem_wdata = DW'(link_now);
            endcase
        end else if (phase == PH_RET) begin
            mem_addr = f_q.q - AW'(3) + AW'(widx);
        end

        f_d        = f_q;
        f_d.rvalid = 1'b0;
        if (call_accept) begin
            f_d.pc_l = call_pc;
            f_d.st_l = call_status;
        end
        if (phase == PH_RET && mem_ready) begin
            if (widx == W_PC)   f_d.rpc = mem_rdata;
            if (widx == W_STAT) f_d.rst = mem_rdata;
        end
        if (call_done) begin
            f_d.sp = f_q.sp + MW;
            f_d.q  = f_q.sp + MW;
        end
        if (ret_done) begin
            f_d.q      = f_q.q - mem_rdata[AW-1:0];
            f_d.sp     = f_q.q - MW;
            f_d.rvalid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{sp: EMPTY, q: EMPTY, pc_l: '0, st_l: '0,
                     rpc: '0, rst: '0, rvalid: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign sp         = f_q.sp;
    assign q          = f_q.q;
    assign ret_pc     = f_q.rpc;
    assign ret_status = f_q.rst;
    assign ret_valid  = f_q.rvalid;

    // R3: completed call raises sp by one marker and aligns q with it
    p_call_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        call_done |=> (sp == $past(sp) + MW) && (q == sp));

    // R5: completed return drops sp to just below the removed marker
    p_ret_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |=> (sp == $past(q) - MW));

    // R7: no write ever lands above the stack limit
    p_write_in_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CALL) |-> (mem_addr <= stack_limit));
endmodule

// File: rtl/proc_marker_ctl.sv
module proc_marker_ctl
    import psm_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int BASE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_req,
    input  logic [DW-1:0] call_pc,
    input  logic [DW-1:0] call_status,
    input  logic          ret_req,
    input  logic [AW-1:0] stack_limit,
    output logic          busy,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] q,
    output logic [DW-1:0] ret_pc,
    output logic [DW-1:0] ret_status,
    output logic          ret_valid,
    output logic          ovf_flag,
    output logic          udf_flag,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);
    typedef struct packed {
        logic ovf;
        logic udf;
    } flg_t;

    flg_t   g_q, g_d;
    phase_t phase;
    logic [1:0] widx;
    logic call_accept, call_done, ret_done, ovf_p, udf_p;
    logic room_ok, frame_live;

    psm_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .call_req    (call_req),
        .ret_req     (ret_req),
        .room_ok     (room_ok),
        .frame_live  (frame_live),
        .mem_ready   (mem_ready),
        .phase       (phase),
        .widx        (widx),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .call_accept (call_accept),
        .call_done   (call_done),
        .ret_done    (ret_done),
        .ovf_p       (ovf_p),
        .udf_p       (udf_p),
        .busy        (busy)
    );

    psm_frame #(.AW(AW), .DW(DW), .BASE(BASE)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .widx        (widx),
        .call_accept (call_accept),
        .call_done   (call_done),
        .ret_done    (ret_done),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .call_pc     (call_pc),
        .call_status (call_status),
        .stack_limit (stack_limit),
        .sp          (sp),
        .q           (q),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .ret_pc      (ret_pc),
        .ret_status  (ret_status),
        .ret_valid   (ret_valid),
        .room_ok     (room_ok),
        .frame_live  (frame_live)
    );

    always_comb begin
        g_d.ovf = ovf_p;
        g_d.udf = udf_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{ovf: 1'b0, udf: 1'b0};
        else        g_q <= g_d;
    end

    assign ovf_flag = g_q.ovf;
    assign udf_flag = g_q.udf;

    // R10: a stalled transfer keeps its request, direction, address and data
    p_hold_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata));

    // R7: a refused call leaves the pointers alone and starts nothing
    p_ovf_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (sp == $past(sp)) && (q == $past(q)) && !busy);

    // R8: a refused return leaves the pointers alone and starts nothing
    p_udf_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        udf_flag |-> (sp == $past(sp)) && (q == $past(q)) && !busy);

    // R6: completion and refusal pulses are mutually exclusive
    p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_flag, udf_flag, ret_valid}));
endmodule

// File: tb/sim_proc_marker_ctl.sv
module sim_proc_marker_ctl;
    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int BASE = 64;
    localparam int NFR  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_req = 1'b0;
    logic [DW-1:0] call_pc = '0;
    logic [DW-1:0] call_status = '0;
    logic          ret_req = 1'b0;
    logic [AW-1:0] stack_limit = AW'(BASE - 1 + 4 * NFR);
    logic          busy, ret_valid, ovf_flag, udf_flag, mem_req, mem_we;
    logic [AW-1:0] sp, q, mem_addr;
    logic [DW-1:0] ret_pc, ret_status, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b0;

    always #2 clk = ~clk;

    proc_marker_ctl #(.AW(AW), .DW(DW), .BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_pc(call_pc),
        .call_status(call_status), .ret_req(ret_req), .stack_limit(stack_limit),
        .busy(busy), .sp(sp), .q(q), .ret_pc(ret_pc), .ret_status(ret_status),
        .ret_valid(ret_valid), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    logic [DW-1:0] mem [0:255];
    int wlog [0:1023];
    int wlog_n = 0;
    int rd_rsv = 0;
    int wcnt = 0, wait_n = 0, wait_mode = 0, txn = 0;
    int nchk = 0, nfail = 0;
    int psp [0:15], pq [0:15];
    logic [DW-1:0] ppc [0:15], pst [0:15];
    int depth = 0;

    // memory model: ready after wait_n stalled cycles
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= wait_n) begin
                mem_ready = 1'b1;
                mem_rdata = mem[mem_addr[7:0]];
            end else begin
                mem_ready = 1'b0;
                wcnt = wcnt + 1;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wlog[wlog_n % 1024] = int'(mem_addr);
                wlog_n = wlog_n + 1;
            end else if ((int'(mem_addr) - int'(q)) == -1) begin
                rd_rsv = rd_rsv + 1;
            end
            wcnt = 0;
            txn = txn + 1;
            wait_n = (wait_mode == 3) ? (txn % 3) : wait_mode;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_call(input logic [DW-1:0] pc, input logic [DW-1:0] st, input bit ok);
        int osp, oq, n0;
        bit ovs;
        osp = int'(sp); oq = int'(q); n0 = wlog_n;
        @(negedge clk); call_req = 1'b1; call_pc = pc; call_status = st;
        @(negedge clk); call_req = 1'b0; ovs = ovf_flag;
        while (busy) @(negedge clk);
        if (ok) begin
            chk(ovs == 1'b0, "R7 accepted call flagged", ovs, 0);
            chk(int'(sp) == osp + 4, "R3 sp after call", sp, osp + 4);
            chk(int'(q) == osp + 4, "R3 q after call", q, osp + 4);
            chk(mem[(osp + 1) % 256] == pc, "R2 pc word", mem[(osp + 1) % 256], pc);
            chk(mem[(osp + 2) % 256] == st, "R2 status word", mem[(osp + 2) % 256], st);
            chk(mem[(osp + 3) % 256] == 0, "R2 reserved word", mem[(osp + 3) % 256], 0);
            chk(int'(mem[(osp + 4) % 256]) == osp + 4 - oq, "R4 link word",
                mem[(osp + 4) % 256], osp + 4 - oq);
            chk(wlog_n == n0 + 4, "R2 write count", wlog_n - n0, 4);
            for (int i = 0; i < 4; i++)
                chk(wlog[(n0 + i) % 1024] == osp + 1 + i, "R2 write order",
                    wlog[(n0 + i) % 1024], osp + 1 + i);
            psp[depth] = osp; pq[depth] = oq; ppc[depth] = pc; pst[depth] = st;
            depth = depth + 1;
        end else begin
            chk(ovs == 1'b1, "R7 overflow flag", ovs, 1);
            chk(int'(sp) == osp && int'(q) == oq, "R7 pointers kept", sp, osp);
            chk(wlog_n == n0, "R7 no write", wlog_n - n0, 0);
        end
    endtask

    task automatic do_ret(input bit ok, input int exp_q, input int exp_sp,
                          input logic [DW-1:0] epc, input logic [DW-1:0] est);
        int osp, oq, r0;
        bit uds;
        osp = int'(sp); oq = int'(q); r0 = txn;
        @(negedge clk); ret_req = 1'b1;
        @(negedge clk); ret_req = 1'b0; uds = udf_flag;
        while (busy) @(negedge clk);
        if (ok) begin
            chk(ret_valid == 1'b1, "R6 ret_valid pulse", ret_valid, 1);
            chk(ret_pc == epc, "R6 ret_pc", ret_pc, epc);
            chk(ret_status == est, "R6 ret_status", ret_status, est);
            chk(int'(q) == exp_q, "R5 q after return", q, exp_q);
            chk(int'(sp) == exp_sp, "R5 sp after return", sp, exp_sp);
            chk(txn - r0 == 3, "R5 three reads", txn - r0, 3);
            @(negedge clk);
            chk(ret_valid == 1'b0, "R6 pulse one cycle", ret_valid, 0);
        end else begin
            chk(uds == 1'b1, "R8 underflow flag", uds, 1);
            chk(int'(sp) == osp && int'(q) == oq, "R8 pointers kept", q, oq);
            chk(txn == r0, "R8 no memory access", txn - r0, 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; depth = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail = nfail + 1;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        do_reset();
        // R1: reset state
        chk(int'(sp) == BASE - 1, "R1 sp reset", sp, BASE - 1);
        chk(int'(q) == BASE - 1, "R1 q reset", q, BASE - 1);
        chk(!busy && !mem_req && !ret_valid && !ovf_flag && !udf_flag,
            "R1 outputs idle", {busy, mem_req, ret_valid, ovf_flag, udf_flag}, 0);

        // R12: fill to the limit, overflow, unwind, underflow; sweep wait states
        for (int wm = 0; wm < 4; wm++) begin
            wait_mode = wm; wait_n = (wm == 3) ? 0 : wm;
            for (int f = 0; f < NFR; f++)
                do_call(DW'(32'h1000 * (wm + 1) + f), DW'(32'hA0 + 7 * f + wm), 1'b1);
            chk(int'(sp) == int'(stack_limit), "R7 frame ending at limit accepted",
                sp, stack_limit);
            do_call(DW'(32'hDEAD), DW'(32'hBEEF), 1'b0);
            for (int f = NFR - 1; f >= 0; f--) begin
                depth = depth - 1;
                do_ret(1'b1, pq[depth], psp[depth], ppc[depth], pst[depth]);
            end
            chk(int'(sp) == BASE - 1 && int'(q) == BASE - 1, "R12 fully unwound", q, BASE - 1);
            do_ret(1'b0, 0, 0, '0, '0);
        end
        chk(rd_rsv == 0, "R5 reserved word never read", rd_rsv, 0);

        // R5: stored link other than one marker size
        wait_mode = 1; wait_n = 1;
        do_call(DW'(32'h51), DW'(32'h61), 1'b1);
        do_call(DW'(32'h52), DW'(32'h62), 1'b1);
        do_call(DW'(32'h53), DW'(32'h63), 1'b1);
        mem[int'(q) % 256] = DW'(9);
        do_ret(1'b1, int'(q) - 9, int'(q) - 4, DW'(32'h53), DW'(32'h63));
        do_reset();

        // R11: simultaneous call and return from empty stack
        @(negedge clk); call_req = 1'b1; ret_req = 1'b1; call_pc = 32'h77; call_status = 32'h88;
        @(negedge clk); call_req = 1'b0; ret_req = 1'b0;
        chk(udf_flag == 1'b0, "R11 return dropped", udf_flag, 0);
        while (busy) @(negedge clk);
        chk(int'(sp) == BASE + 3 && int'(q) == BASE + 3, "R11 call served", sp, BASE + 3);

        // R9: requests while busy are ignored
        begin
            int n0, bz;
            n0 = wlog_n; bz = 0;
            wait_mode = 2; wait_n = 2;
            @(negedge clk); call_req = 1'b1; call_pc = 32'h99; call_status = 32'h11;
            @(negedge clk); call_req = 1'b0;
            bz = busy;
            repeat (3) @(negedge clk);
            ret_req = 1'b1; call_req = 1'b1;
            @(negedge clk); ret_req = 1'b0; call_req = 1'b0;
            while (busy) @(negedge clk);
            chk(bz == 1, "R9 busy after accept", bz, 1);
            repeat (3) @(negedge clk);
            chk(int'(sp) == BASE + 7 && int'(q) == BASE + 7, "R9 one call only", sp, BASE + 7);
            chk(wlog_n == n0 + 4, "R9 no extra writes", wlog_n - n0, 4);
            chk(!busy && !udf_flag && !ret_valid, "R9 idle after", busy, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule